// File: doc/BRIEF.md
# Configurable-Latency Carry-Save Signed Multiplier

This block multiplies a signed multiplicand by a signed multiplier, both in two's complement. A one-cycle start pulse launches a calculation. The multiplier is sampled in that cycle. The block then works through the multiplier bits, least significant first, over a number of cycles set by a parameter. Each processed bit adds the multiplicand, or nothing, to a partial product. That partial product is kept in redundant sum-and-carry form, so a carry never has to travel along the word inside the loop. The top bit of the multiplier carries a negative weight, so its step subtracts the multiplicand instead of adding it.

No separate multiplier register exists. The sampled multiplier is loaded into the low half of the product shift register. Each cycle shifts out the bits just consumed and shifts in the resolved low product bits. A final adder merges the sum and carry words into the high product bits. This adder can either drive the output directly or feed a one-cycle output register.

When the latency parameter is below the multiplier width, several bits are handled per cycle. When it is at or above that width, one bit is handled per cycle and the multiplier is sign-extended to fill the cycles. A latency of zero turns the whole block into combinational logic. A one-cycle ready pulse marks the cycle in which the product is valid.

Top module: `cs_multiplier`

## Requirements
- R1: When ready is high, product equals the signed product of the multiplicand and the sampled multiplier, as a two's-complement number MCAND_W+MPLR_W bits wide.
- R2: ready is high for exactly one cycle. For an accepted start in cycle 0, it is high in cycle LATENCY+CONV_LAT and low in every cycle in between.
- R3: The multiplier is sampled only in the cycle of an accepted start. Changing it afterwards has no effect on the result. The multiplicand must be held stable until ready.
- R4: With 0 < LATENCY < MPLR_W, each cycle consumes ceil(MPLR_W/LATENCY) multiplier bits. The multiplier is sign-extended to LATENCY times that count, and ready still follows the timing of R2.
- R5: With LATENCY >= MPLR_W, one bit is consumed per cycle. The multiplier is sign-extended to LATENCY bits, and ready follows the timing of R2.
- R6: With LATENCY = 0 the datapath is combinational. With CONV_LAT = 0, ready equals start in the same cycle, and starts in consecutive cycles each produce their own correct product.
- R7: With CONV_LAT = 1, product comes from a register. It keeps the last result from its ready cycle until the next ready, even while a new calculation runs.
- R8: With LATENCY >= 2, a start in cycles 1 to LATENCY-1 after an accepted start is ignored. It changes neither the pending result nor the ready timing, and it produces no extra ready.
- R9: rst is asynchronous and active high. It forces ready low at once and, with CONV_LAT = 1, forces product to zero. It aborts any calculation in progress, and a start after release works normally.
- R10: The corner operands are correct in every configuration. These are the most negative value times itself, either operand zero, either operand -1, and the largest positive values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | One-cycle pulse that launches a multiplication |
| mcand | input | MCAND_W | Signed multiplicand, held stable until ready |
| mplr | input | MPLR_W | Signed multiplier, sampled with start |
| ready | output | 1 | One-cycle pulse marking a valid product |
| product | output | MCAND_W+MPLR_W | Signed product, valid while ready is high |

## Verification
The embedded properties check the following on every cycle:
- The step counter advances by one even when start arrives mid-calculation.
- The busy state ends exactly when the completion flag rises.
- ready never stays high for two cycles in a row.
- The conversion register follows the internal completion flag by one cycle.

Only the bench's scenarios show the rest:
- Numeric correctness of the product, including the sign-step subtraction and the pending carry it leaves for the final adder.
- The exact cycle in which ready appears for each latency setting.
- That a late multiplier change or an ignored start leaves the result unchanged.
- That the registered output holds across a following calculation.

// File: rtl/cs_multiplier.sv
module cs_multiplier #(
  parameter int MCAND_W  = 8,
  parameter int MPLR_W   = 8,
  parameter int LATENCY  = 4,
  parameter int CONV_LAT = 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [MCAND_W-1:0]          mcand,
  input  logic [MPLR_W-1:0]           mplr,
  output logic                        ready,
  output logic [MCAND_W+MPLR_W-1:0]   product
);

  localparam int NB    = (LATENCY == 0) ? MPLR_W : (MPLR_W + LATENCY - 1) / LATENCY;
  localparam int STEPS = (LATENCY == 0) ? 1 : LATENCY;
  localparam int EW    = NB * STEPS;
  localparam int W     = MCAND_W + 1;
  localparam int PW    = MCAND_W + MPLR_W;
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic [W-1:0]  acc_s, acc_c;
  logic          pend_q;
  logic [EW-1:0] shreg;
  logic          busy, done;
  logic [CW-1:0] cnt, cur;
  logic          accept, step_en, last;

  logic [W-1:0]  mx;
  logic [EW-1:0] mplr_ext, in_r, next_r;
  logic [W-1:0]  in_s, in_c;
  logic [W-1:0]  ch_s [0:NB];
  logic [W-1:0]  ch_c [0:NB];
  logic [NB-1:0] obits;
  logic          pend_n;

  logic [MCAND_W-1:0]    top;
  logic [MCAND_W+EW-1:0] full;
  logic [PW-1:0]         result;
  logic                  rdy_raw;

  assign mx       = W'($signed(mcand));
  assign mplr_ext = EW'($signed(mplr));

  assign accept  = start && !busy;
  assign step_en = accept || busy;
  assign cur     = accept ? '0 : cnt;
  assign last    = (cur == CW'(STEPS - 1));

  assign in_s = accept ? '0 : acc_s;
  assign in_c = accept ? '0 : acc_c;
  assign in_r = accept ? mplr_ext : shreg;

  assign ch_s[0] = in_s;
  assign ch_c[0] = in_c;

  for (genvar j = 0; j < NB; j++) begin : g_cell
    logic         sub;
    logic [W-1:0] ad, sv, cv;
    assign sub = in_r[j] & last & (j == NB - 1);
    assign ad  = in_r[j] ? (sub ? ~mx : mx) : '0;
    assign sv  = ch_s[j] ^ ch_c[j] ^ ad;
    assign cv  = (ch_s[j] & ch_c[j]) | (ch_s[j] & ad) | (ch_c[j] & ad);
    assign ch_s[j+1] = {sv[W-1], sv[W-1:1]};
    assign ch_c[j+1] = cv;
    assign obits[j]  = sv[0] ^ sub;
    if (j == NB - 1) begin : g_top
      assign pend_n = sub & sv[0];
    end
  end

  if (EW > NB) begin : g_shift
    assign next_r = {obits, in_r[EW-1:NB]};
  end else begin : g_noshift
    assign next_r = obits;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      acc_s  <= '0;
      acc_c  <= '0;
      pend_q <= 1'b0;
      shreg  <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
    end else begin
      done <= 1'b0;
      if (step_en) begin
        acc_s  <= ch_s[NB];
        acc_c  <= ch_c[NB];
        pend_q <= pend_n;
        shreg  <= next_r;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          cnt  <= '0;
        end else begin
          busy <= 1'b1;
          cnt  <= cur + CW'(1);
        end
      end
    end
  end

  if (LATENCY == 0) begin : g_comb
    assign top     = ch_s[NB][MCAND_W-1:0] + ch_c[NB][MCAND_W-1:0] + MCAND_W'(pend_n);
    assign full    = {top, next_r};
    assign rdy_raw = accept;
  end else begin : g_seq
    assign top     = acc_s[MCAND_W-1:0] + acc_c[MCAND_W-1:0] + MCAND_W'(pend_q);
    assign full    = {top, shreg};
    assign rdy_raw = done;
  end

  assign result = full[PW-1:0];

  if (CONV_LAT == 1) begin : g_conv_reg
    logic [PW-1:0] prod_q;
    logic          rdy_q;
    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        prod_q <= '0;
        rdy_q  <= 1'b0;
      end else begin
        rdy_q <= rdy_raw;
        if (rdy_raw) prod_q <= result;
      end
    end
    assign product = prod_q;
    assign ready   = rdy_q;

    p_conv_follow_r7: assert property (@(posedge clk) disable iff (rst)
      rdy_raw |=> ready);
  end else begin : g_conv_comb
    assign product = result;
    assign ready   = rdy_raw;
  end

  // R8: the step counter keeps advancing whatever start does mid-run
  p_count_advance_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> (busy && cnt == $past(cnt) + CW'(1)));

  p_busy_end_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  if (LATENCY > 1) begin : g_pulse_chk
    p_ready_single_r2: assert property (@(posedge clk) disable iff (rst)
      ready |=> !ready);
  end

  if (LATENCY == 0 && CONV_LAT == 0) begin : g_comb_chk
    p_comb_ready_r6: assert property (@(posedge clk) disable iff (rst)
      start |-> ready);
  end

endmodule

// File: tb/test_cs_multiplier.sv
`timescale 1ns/100ps

module tb_lane #(
  parameter int A    = 8,
  parameter int B    = 8,
  parameter int LAT  = 4,
  parameter int CV   = 1,
  parameter int SEED = 1
) (
  input  logic clk,
  output int   nchk,
  output int   nfail,
  output logic fin
);
  localparam int PW = A + B;
  localparam int D  = LAT + CV;

  logic          rst, start, ready;
  logic [A-1:0]  mcand;
  logic [B-1:0]  mplr;
  logic [PW-1:0] product;
  logic [PW-1:0] last_e;
  string         lat_tag;

  cs_multiplier #(.MCAND_W(A), .MPLR_W(B), .LATENCY(LAT), .CONV_LAT(CV)) i_cs_multiplier (
    .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplr(mplr),
    .ready(ready), .product(product));

  function automatic logic [PW-1:0] exp_prod(logic [A-1:0] a, logic [B-1:0] b);
    longint p = longint'($signed(a)) * longint'($signed(b));
    return p[PW-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s lane(A=%0d B=%0d LAT=%0d CV=%0d) actual=%0h expected=%0h",
               req, A, B, LAT, CV, act, expv);
    end
  endtask

  task automatic do_mul(input logic [A-1:0] a, input logic [B-1:0] b, input string ptag);
    logic [PW-1:0] e = exp_prod(a, b);
    logic [PW-1:0] prev = last_e;
    @(negedge clk);
    mcand = a; mplr = b; start = 1'b1;
    if (D == 0) begin
      #1;
      chk(ready === 1'b1, "R6 ready with start", longint'(ready), 1);
      chk(product === e, ptag, longint'(product), longint'(e));
      @(negedge clk);
      start = 1'b0;
      mplr = B'($urandom);
      #1;
      chk(ready === 1'b0, "R6 ready drops with start", longint'(ready), 0);
    end else begin
      for (int k = 1; k <= D; k++) begin
        @(negedge clk);
        if (k == 1) begin
          start = 1'b0;
          mplr = B'($urandom);   // R3: late multiplier change
        end
        if (k < D) begin
          chk(ready === 1'b0, "R2 early ready", longint'(ready), 0);
          if (CV == 1) chk(product === prev, "R7 output hold", longint'(product), longint'(prev));
        end else begin
          chk(ready === 1'b1, lat_tag, longint'(ready), 1);
          chk(product === e, ptag, longint'(product), longint'(e));
        end
      end
      @(negedge clk);
      chk(ready === 1'b0, "R2 pulse width", longint'(ready), 0);
    end
    last_e = e;
  endtask

  task automatic ign_test(input logic [A-1:0] a, input logic [B-1:0] b, input logic [B-1:0] b2);
    logic [PW-1:0] e = exp_prod(a, b);
    @(negedge clk);
    mcand = a; mplr = b; start = 1'b1;
    for (int k = 1; k <= D; k++) begin
      @(negedge clk);
      if (k == 1) mplr = b2;
      if (k == 2) start = 1'b0;
      if (k < D) chk(ready === 1'b0, "R8 early ready", longint'(ready), 0);
      else begin
        chk(ready === 1'b1, "R8 ready timing", longint'(ready), 1);
        chk(product === e, "R8 result of first start", longint'(product), longint'(e));
      end
    end
    @(negedge clk);
    chk(ready === 1'b0, "R8 no second ready", longint'(ready), 0);
    last_e = e;
  endtask

  initial begin
    logic [A-1:0] amin, amax, aneg1;
    logic [B-1:0] bmin, bmax, bneg1;
    void'($urandom(SEED));
    amin = A'(1) << (A - 1); amax = ~amin; aneg1 = '1;
    bmin = B'(1) << (B - 1); bmax = ~bmin; bneg1 = '1;
    lat_tag = (LAT == 0) ? "R6 latency" : (LAT < B) ? "R4 latency" : "R5 latency";
    nchk = 0; nfail = 0; fin = 1'b0;
    rst = 1'b1; start = 1'b0; mcand = '0; mplr = '0; last_e = '0;
    repeat (3) @(negedge clk);
    chk(ready === 1'b0, "R9 reset ready", longint'(ready), 0);
    if (CV == 1) chk(product === '0, "R9 reset product", longint'(product), 0);
    rst = 1'b0;

    // R10 corners
    do_mul(amin, bmin, "R10 min*min");
    do_mul(amin, '0, "R10 min*0");
    do_mul('0, bmin, "R10 0*min");
    do_mul(amin, bneg1, "R10 min*-1");
    do_mul(aneg1, bmin, "R10 -1*min");
    do_mul(aneg1, bneg1, "R10 -1*-1");
    do_mul(amax, bmax, "R10 max*max");
    do_mul(amax, bmin, "R10 max*min");
    do_mul(A'(1), B'(1), "R10 1*1");

    for (int i = 0; i < 40; i++) do_mul(A'($urandom), B'($urandom), "R1 random product");

    if (LAT >= 2) begin
      ign_test(amin, bneg1, bmin);
      ign_test(A'($urandom), B'($urandom), B'($urandom));
    end

    if (D == 0) begin
      // R6 back-to-back starts
      for (int i = 0; i < 8; i++) begin
        logic [A-1:0] a = A'($urandom);
        logic [B-1:0] b = B'($urandom);
        @(negedge clk);
        mcand = a; mplr = b; start = 1'b1;
        #1;
        chk(ready === 1'b1, "R6 back-to-back ready", longint'(ready), 1);
        chk(product === exp_prod(a, b), "R6 back-to-back product",
            longint'(product), longint'(exp_prod(a, b)));
      end
      @(negedge clk);
      start = 1'b0;
    end

    // R9 asynchronous reset mid-calculation
    @(negedge clk);
    mcand = amin; mplr = bmin; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1 rst = 1'b1;
    #1;
    chk(ready === 1'b0, "R9 async reset ready", longint'(ready), 0);
    if (CV == 1) chk(product === '0, "R9 async reset product", longint'(product), 0);
    last_e = '0;
    @(negedge clk);
    rst = 1'b0;
    do_mul(amax, bneg1, "R9 product after reset");

    fin = 1'b1;
  end
endmodule

module test_cs_multiplier;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  localparam int NL = 6;
  int   c [NL];
  int   f [NL];
  logic d [NL];

  tb_lane #(.A(8), .B(8), .LAT(4), .CV(1), .SEED(11)) i_l0 (.clk(clk), .nchk(c[0]), .nfail(f[0]), .fin(d[0]));
  tb_lane #(.A(8), .B(8), .LAT(3), .CV(0), .SEED(12)) i_l1 (.clk(clk), .nchk(c[1]), .nfail(f[1]), .fin(d[1]));
  tb_lane #(.A(6), .B(4), .LAT(7), .CV(1), .SEED(13)) i_l2 (.clk(clk), .nchk(c[2]), .nfail(f[2]), .fin(d[2]));
  tb_lane #(.A(5), .B(5), .LAT(0), .CV(0), .SEED(14)) i_l3 (.clk(clk), .nchk(c[3]), .nfail(f[3]), .fin(d[3]));
  tb_lane #(.A(4), .B(6), .LAT(1), .CV(0), .SEED(15)) i_l4 (.clk(clk), .nchk(c[4]), .nfail(f[4]), .fin(d[4]));
  tb_lane #(.A(7), .B(5), .LAT(0), .CV(1), .SEED(16)) i_l5 (.clk(clk), .nchk(c[5]), .nfail(f[5]), .fin(d[5]));

  initial begin
    bit timeout = 1'b0;
    int total = 0;
    int bad = 0;
    fork
      wait (d[0] && d[1] && d[2] && d[3] && d[4] && d[5]);
      begin
        repeat (150000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    for (int i = 0; i < NL; i++) begin
      total += c[i];
      bad += f[i];
    end
    if (timeout) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
    end
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end
endmodule